// File: doc/BRIEF.md
# Receive-Side Acknowledgement Scheduler

This block sits in the link layer of a serial point-to-point receiver. It decides when an acknowledgement for received transaction packets goes back to the sender. Each received packet is reported to it as a one-cycle completion event. The event carries the packet's sequence number and a flag saying whether the packet's CRC was good. In-order good packets are grouped together and covered by a single positive acknowledgement (ACK). That ACK carries the highest in-order sequence number. A packet with a CRC error instead triggers a negative acknowledgement (NAK) at the first opportunity.

The deadline for an ACK is not a fixed timer. It is recomputed from the programmed maximum payload size, the link width and an acknowledgement factor, plus a fixed internal processing delay. A fixed wake-up adjustment is added while the link is leaving its low-power standby state. One clock cycle equals one symbol time.

Each acknowledgement is turned into an 8-symbol frame by a built-in serializer. The two CRC symbols are left as zero placeholders, to be filled in by a downstream unit.

Top module: `dllp_ack_scheduler`

## Requirements
- R1: Every frame is exactly 8 consecutive valid symbols, in this order: start control symbol 0x5C (k=1), type byte, 0x00, upper sequence byte (zero-padded), lower sequence byte, two CRC placeholders of 0x00, and end control symbol 0xFD (k=1). All data symbols have k=0.
- R2: The type byte is 0x00 for an ACK and 0x10 for a NAK. The sequence field is the highest in-order good sequence number, which is the expected number minus one, modulo 4096. The expected number is 0 after reset.
- R3: Let L = floor(((128 << payload_code) + 28) × F / W) + 19. Here W is the lane count selected by width code 0..6 = 1, 2, 4, 8, 12, 16, 32 (code 7 means 32), and payload codes above 5 mean 5. When no frame is in progress, the first symbol of an ACK appears L cycles after the edge that accepted the first unacknowledged in-order good packet.
- R4: The acknowledgement factor F is the programmed value 1, 2 or 3. A programmed 0 is used as 1.
- R5: While the low-power exit input is high, 20 is added to L.
- R6: Further in-order good packets that arrive before the deadline neither restart nor extend it. They are covered by the same single ACK, which carries the newest sequence number.
- R7: A packet with a bad CRC causes a NAK whose first symbol appears one cycle after the accepting edge when no frame is in progress.
- R8: A pending NAK is sent ahead of a pending ACK. Sending the NAK also retires the pending ACK, so no ACK follows it.
- R9: After a NAK has been scheduled, further bad packets schedule no NAK until an in-order good packet arrives.
- R10: A good packet whose sequence number differs from the expected one is dropped. It schedules nothing and does not advance the sequence.
- R11: After reset, and whenever nothing awaits acknowledgement, no symbol is emitted and the latency counter rests at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one symbol time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | One-cycle completion event for a received packet |
| rx_seq | input | 12 | Sequence number of the completed packet |
| rx_crc_ok | input | 1 | 1 = packet CRC good, 0 = CRC error |
| cfg_payload_code | input | 3 | Maximum payload size, 128 << code bytes |
| cfg_width_code | input | 3 | Link lane-count code |
| cfg_ack_factor | input | 2 | Acknowledgement factor, 1 to 3 |
| l0s_exit | input | 1 | High while the link wakes from standby |
| dllp_valid | output | 1 | Symbol on dllp_sym is valid |
| dllp_sym | output | 8 | Frame symbol |
| dllp_k | output | 1 | Symbol is a control character |

## Verification
The deadline assertion assumes that the configuration inputs and the wake-up input stay still while a packet awaits acknowledgement. Without that, the registered limit could move under the running counter. The assertions also assume completion events are single-cycle pulses carrying a 12-bit sequence number.

The directed stimulus changes configuration only while the scheduler is idle. After each change it waits several cycles before sending a packet. Every packet is a one-cycle pulse presented between clock edges. Each expected latency is computed in the bench from the programmed values using the formula in R3.

// File: rtl/dllp_sched_pkg.sv
package dllp_sched_pkg;
  localparam int          SEQ_W      = 12;
  localparam int          LIM_W      = 15;
  localparam int          PKT_OVHD   = 28;
  localparam int          PROC_DELAY = 19;
  localparam int          WAKE_ADJ   = 20;
  localparam int          BASE_MPS   = 128;
  localparam int          MAX_PCODE  = 5;
  localparam int          FRAME_LEN  = 8;
  localparam logic [7:0]  K_START    = 8'h5C;
  localparam logic [7:0]  K_END      = 8'hFD;
  localparam logic [7:0]  TYPE_ACK   = 8'h00;
  localparam logic [7:0]  TYPE_NAK   = 8'h10;

  typedef enum logic [2:0] {
    LW_X1  = 3'd0,
    LW_X2  = 3'd1,
    LW_X4  = 3'd2,
    LW_X8  = 3'd3,
    LW_X12 = 3'd4,
    LW_X16 = 3'd5,
    LW_X32 = 3'd6
  } lane_code_e;
endpackage

// File: rtl/ack_limit_calc.sv
module ack_limit_calc
  import dllp_sched_pkg::*;
#(
  parameter int LW = LIM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    payload_code,
  input  logic [2:0]    width_code,
  input  logic [1:0]    ack_factor,
  input  logic          wake,
  output logic [LW-1:0] limit
);
  logic [2:0]    pcode;
  logic [1:0]    factor;
  logic [LW-1:0] mps, scaled, per_lane, next_lim, quarter;

  always_comb begin
    pcode    = (payload_code > 3'(MAX_PCODE)) ? 3'(MAX_PCODE) : payload_code;
    factor   = (ack_factor == 2'd0) ? 2'd1 : ack_factor;
    mps      = LW'(BASE_MPS) << pcode;
    scaled   = (mps + LW'(PKT_OVHD)) * LW'(factor);
    quarter  = scaled >> 2;
    case (lane_code_e'(width_code))
      LW_X1:   per_lane = scaled;
      LW_X2:   per_lane = scaled >> 1;
      LW_X4:   per_lane = quarter;
      LW_X8:   per_lane = scaled >> 3;
      LW_X12:  per_lane = quarter / LW'(3);
      LW_X16:  per_lane = scaled >> 4;
      default: per_lane = scaled >> 5;
    endcase
    next_lim = per_lane + LW'(PROC_DELAY) + (wake ? LW'(WAKE_ADJ) : LW'(0));
  end

  always_ff @(posedge clk) begin
    if (rst) limit <= LW'(PROC_DELAY);
    else     limit <= next_lim;
  end

  AST_LIMIT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    limit >= LW'(PROC_DELAY)) else $error("limit below internal delay"); // R3
endmodule

// File: rtl/ack_seq_tracker.sv
module ack_seq_tracker
  import dllp_sched_pkg::*;
#(
  parameter int SW = SEQ_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_done,
  input  logic [SW-1:0] rx_seq,
  input  logic          rx_crc_ok,
  input  logic          ack_sent,
  input  logic          nak_sent,
  output logic          ack_pending,
  output logic          nak_pending,
  output logic [SW-1:0] last_good
);
  logic [SW-1:0] expect_seq;
  logic          nak_armed_n;
  logic          good_pkt, bad_pkt;

  assign good_pkt  = rx_done && rx_crc_ok && (rx_seq == expect_seq);
  assign bad_pkt   = rx_done && !rx_crc_ok;
  assign last_good = expect_seq - SW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_seq  <= '0;
      ack_pending <= 1'b0;
      nak_pending <= 1'b0;
      nak_armed_n <= 1'b0;
    end else begin
      if (good_pkt) expect_seq <= expect_seq + SW'(1);

      if (good_pkt)                  ack_pending <= 1'b1;
      else if (ack_sent || nak_sent) ack_pending <= 1'b0;

      if (bad_pkt && !nak_armed_n) nak_pending <= 1'b1;
      else if (nak_sent)           nak_pending <= 1'b0;

      if (good_pkt)     nak_armed_n <= 1'b0;
      else if (bad_pkt) nak_armed_n <= 1'b1;
    end
  end

  AST_NAK_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    (nak_armed_n && !nak_pending && !good_pkt) |=> !nak_pending)
    else $error("second NAK scheduled"); // R9
  AST_NO_SEQ_SKIP: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_seq != expect_seq) |=> (last_good == $past(last_good)))
    else $error("sequence advanced on mismatch"); // R10
endmodule

// File: rtl/dllp_framer.sv
module dllp_framer
  import dllp_sched_pkg::*;
#(
  parameter int SW = SEQ_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          launch_nak,
  input  logic [SW-1:0] launch_seq,
  output logic          ready,
  output logic          sym_valid,
  output logic [7:0]    sym,
  output logic          sym_k
);
  localparam int IW = $clog2(FRAME_LEN);

  logic          active;
  logic [IW-1:0] idx;
  logic          nak_q;
  logic [SW-1:0] seq_q;
  logic [15:0]   seq16;
  logic [8:0]    body;

  assign ready = !active;
  assign seq16 = 16'(seq_q);

  always_comb begin
    case (idx)
      IW'(1):  body = {1'b0, nak_q ? TYPE_NAK : TYPE_ACK};
      IW'(3):  body = {1'b0, seq16[15:8]};
      IW'(4):  body = {1'b0, seq16[7:0]};
      IW'(7):  body = {1'b1, K_END};
      default: body = 9'h000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      idx       <= '0;
      nak_q     <= 1'b0;
      seq_q     <= '0;
      sym_valid <= 1'b0;
      sym       <= '0;
      sym_k     <= 1'b0;
    end else if (!active) begin
      if (launch) begin
        active    <= 1'b1;
        idx       <= IW'(1);
        nak_q     <= launch_nak;
        seq_q     <= launch_seq;
        sym_valid <= 1'b1;
        sym       <= K_START;
        sym_k     <= 1'b1;
      end else begin
        sym_valid <= 1'b0;
        sym       <= '0;
        sym_k     <= 1'b0;
      end
    end else begin
      sym_valid    <= 1'b1;
      {sym_k, sym} <= body;
      idx          <= idx + IW'(1);
      if (idx == IW'(FRAME_LEN - 1)) active <= 1'b0;
    end
  end

  AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
    $rose(sym_valid) |-> (sym_k && sym == K_START))
    else $error("frame did not open with start"); // R1
  AST_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    $fell(sym_valid) |-> ($past(sym_k) && $past(sym) == K_END))
    else $error("frame did not close with end"); // R1
endmodule

// File: rtl/dllp_ack_scheduler.sv
module dllp_ack_scheduler
  import dllp_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_done,
  input  logic [SEQ_W-1:0] rx_seq,
  input  logic             rx_crc_ok,
  input  logic [2:0]       cfg_payload_code,
  input  logic [2:0]       cfg_width_code,
  input  logic [1:0]       cfg_ack_factor,
  input  logic             l0s_exit,
  output logic             dllp_valid,
  output logic [7:0]       dllp_sym,
  output logic             dllp_k
);
  logic [LIM_W-1:0] limit, cnt;
  logic             ack_pending, nak_pending, ready;
  logic             go_nak, go_ack, go;
  logic [SEQ_W-1:0] last_good;

  ack_limit_calc #(.LW(LIM_W)) u_limit (
    .clk(clk), .rst(rst),
    .payload_code(cfg_payload_code), .width_code(cfg_width_code),
    .ack_factor(cfg_ack_factor), .wake(l0s_exit), .limit(limit)
  );

  ack_seq_tracker #(.SW(SEQ_W)) u_track (
    .clk(clk), .rst(rst),
    .rx_done(rx_done), .rx_seq(rx_seq), .rx_crc_ok(rx_crc_ok),
    .ack_sent(go_ack), .nak_sent(go_nak),
    .ack_pending(ack_pending), .nak_pending(nak_pending), .last_good(last_good)
  );

  assign go_nak = ready && nak_pending;
  assign go_ack = ready && !nak_pending && ack_pending && (cnt >= limit - LIM_W'(1));
  assign go     = go_nak || go_ack;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (go)          cnt <= '0;
    else if (ack_pending) cnt <= cnt + LIM_W'(1);
    else                  cnt <= '0;
  end

  dllp_framer #(.SW(SEQ_W)) u_frame (
    .clk(clk), .rst(rst),
    .launch(go), .launch_nak(go_nak), .launch_seq(last_good),
    .ready(ready),
    .sym_valid(dllp_valid), .sym(dllp_sym), .sym_k(dllp_k)
  );

  AST_ACK_DEADLINE: assert property (@(posedge clk) disable iff (rst)
    ack_pending |-> (cnt <= limit + LIM_W'(FRAME_LEN)))
    else $error("ACK overdue"); // R3
  AST_NAK_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ready && nak_pending && ack_pending) |=> (dllp_valid && !ack_pending))
    else $error("NAK lost priority"); // R8
  AST_IDLE_REST: assert property (@(posedge clk) disable iff (rst)
    (!ack_pending && !nak_pending && ready) |=> !dllp_valid)
    else $error("symbol while idle"); // R11
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_pending) |=> (cnt == '0))
    else $error("counter not at rest"); // R11
endmodule

// File: tb/dllp_ack_scheduler_bench.sv
module dllp_ack_scheduler_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        rx_done, rx_crc_ok, l0s_exit;
  logic [11:0] rx_seq;
  logic [2:0]  cfg_payload_code, cfg_width_code;
  logic [1:0]  cfg_ack_factor;
  logic        dllp_valid, dllp_k;
  logic [7:0]  dllp_sym;

  int compared = 0;
  int mismatched = 0;
  logic [11:0] exp_next = 12'd0;
  logic [8:0]  got [8];

  always #10 clk = ~clk;

  dllp_ack_scheduler u_dllp_ack_scheduler (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_seq(rx_seq), .rx_crc_ok(rx_crc_ok),
    .cfg_payload_code(cfg_payload_code), .cfg_width_code(cfg_width_code),
    .cfg_ack_factor(cfg_ack_factor), .l0s_exit(l0s_exit),
    .dllp_valid(dllp_valid), .dllp_sym(dllp_sym), .dllp_k(dllp_k)
  );

  function automatic int calc_lim(int pc, int wc, int af, bit wake);
    int lanes[8] = '{1, 2, 4, 8, 12, 16, 32, 32};
    int f = (af == 0) ? 1 : af;
    int p = (pc > 5) ? 5 : pc;
    return (((128 << p) + 28) * f) / lanes[wc] + 19 + (wake ? 20 : 0);
  endfunction

  function automatic logic [8:0] exp_sym(int i, bit nak, logic [11:0] s);
    case (i)
      0: return {1'b1, 8'h5C};
      1: return {1'b0, nak ? 8'h10 : 8'h00};
      3: return {5'b0, s[11:8]};
      4: return {1'b0, s[7:0]};
      7: return {1'b1, 8'hFD};
      default: return 9'h000;
    endcase
  endfunction

  task automatic check(string req, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic send(logic [11:0] s, bit ok);
    rx_done = 1'b1; rx_seq = s; rx_crc_ok = ok;
    @(posedge clk); @(negedge clk);
    rx_done = 1'b0;
    if (ok && s == exp_next) exp_next = exp_next + 12'd1;
  endtask

  task automatic configure(int pc, int wc, int af, bit wake);
    cfg_payload_code = 3'(pc); cfg_width_code = 3'(wc);
    cfg_ack_factor = 2'(af); l0s_exit = wake;
    idle(3);
  endtask

  // waits for a frame start, returns edges waited (-1 if none), captures symbols
  task automatic grab(int maxw, output int n);
    n = -1;
    for (int i = 1; i <= maxw; i++) begin
      @(posedge clk); @(negedge clk);
      if (dllp_valid) begin n = i; break; end
    end
    if (n > 0) begin
      got[0] = {dllp_k, dllp_sym};
      for (int j = 1; j < 8; j++) begin
        @(posedge clk); @(negedge clk);
        got[j] = dllp_valid ? {dllp_k, dllp_sym} : 9'h1FF;
      end
    end
  endtask

  task automatic check_frame(string req, bit nak, logic [11:0] s);
    int bad = 0;
    for (int j = 0; j < 8; j++) if (got[j] !== exp_sym(j, nak, s)) bad++;
    check(req, bad, 0);
  endtask

  task automatic t_reset;
    int n;
    check("R11 reset valid", int'(dllp_valid), 0);
    grab(50, n);
    check("R11 no frame when idle", n, -1);
  endtask

  task automatic t_single_ack;
    int n;
    configure(1, 2, 2, 1'b0);
    send(exp_next, 1'b1);
    grab(400, n);
    check("R3 ACK latency x4", n, calc_lim(1, 2, 2, 0));
    check_frame("R1 R2 ACK frame", 1'b0, exp_next - 12'd1);
  endtask

  task automatic t_coalesce;
    int n;
    configure(0, 6, 1, 1'b0);
    send(exp_next, 1'b1);
    idle(2);
    send(exp_next, 1'b1);
    send(exp_next, 1'b1);
    grab(200, n);
    check("R6 deadline kept", n + 4, calc_lim(0, 6, 1, 0));
    check_frame("R6 highest seq", 1'b0, exp_next - 12'd1);
    grab(60, n);
    check("R6 single ACK", n, -1);
  endtask

  task automatic t_factor_zero;
    int n;
    configure(0, 6, 0, 1'b0);
    send(exp_next, 1'b1);
    grab(200, n);
    check("R4 factor 0 as 1", n, calc_lim(0, 6, 1, 0));
    configure(0, 3, 3, 1'b0);
    send(exp_next, 1'b1);
    grab(400, n);
    check("R4 factor 3", n, calc_lim(0, 3, 3, 0));
  endtask

  task automatic t_wake;
    int n;
    configure(0, 6, 1, 1'b1);
    send(exp_next, 1'b1);
    grab(200, n);
    check("R5 wake adjust", n, calc_lim(0, 6, 1, 1));
    configure(0, 6, 1, 1'b0);
  endtask

  task automatic t_x12;
    int n;
    configure(2, 4, 3, 1'b0);
    send(exp_next, 1'b1);
    grab(400, n);
    check("R3 x12 latency", n, calc_lim(2, 4, 3, 0));
  endtask

  task automatic t_nak;
    int n;
    configure(0, 6, 1, 1'b0);
    send(12'h555, 1'b0);
    grab(20, n);
    check("R7 NAK timing", n, 1);
    check_frame("R2 R7 NAK frame", 1'b1, exp_next - 12'd1);
    send(12'h556, 1'b0);
    grab(40, n);
    check("R9 NAK suppressed", n, -1);
    send(exp_next, 1'b1);
    idle(2);
    send(12'h557, 1'b0);
    grab(20, n);
    check("R9 NAK rearmed R8 priority", n, 1);
    check_frame("R8 NAK carries seq", 1'b1, exp_next - 12'd1);
    grab(60, n);
    check("R8 ACK retired", n, -1);
  endtask

  task automatic t_out_of_order;
    int n;
    configure(0, 6, 1, 1'b0);
    send(exp_next + 12'd5, 1'b1);
    grab(60, n);
    check("R10 ooo ignored", n, -1);
    send(exp_next, 1'b1);
    grab(200, n);
    check("R10 seq unchanged", n, calc_lim(0, 6, 1, 0));
    check_frame("R10 frame seq", 1'b0, exp_next - 12'd1);
  endtask

  task automatic t_wrap;
    int n;
    configure(0, 6, 1, 1'b0);
    rst = 1'b1; idle(2); rst = 1'b0; exp_next = 12'd0;
    idle(2);
    send(12'h3, 1'b0);
    grab(20, n);
    check("R2 NAK before any good", n, 1);
    check_frame("R2 seq wraps to FFF", 1'b1, 12'hFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1'b1; rx_done = 1'b0; rx_seq = '0; rx_crc_ok = 1'b1;
    cfg_payload_code = 3'd0; cfg_width_code = 3'd6; cfg_ack_factor = 2'd1; l0s_exit = 1'b0;
    @(negedge clk); idle(3);
    rst = 1'b0;
    idle(1);
    t_reset;
    t_single_ack;
    t_coalesce;
    t_factor_zero;
    t_wake;
    t_x12;
    t_nak;
    t_out_of_order;
    t_wrap;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule